// File: doc/BRIEF.md
# Programmable Integer Divider from Cascaded Divide-by-2/3 Cells

This block divides a fast input clock by an integer between 32 and 127 and emits one output pulse per divided period. It is built as a ripple-style chain of six divide-by-2/3 cells modelled as synchronous clock-enabled stages. A cell stretches its own cycle from two input events to three when its program bit is set and the modulus request coming down from the cell above it is active. The chain's native range is 64 to 127. A bypass path extends it down to 32: when the top ratio bit is clear, the top cell is disabled and the modulus input of the cell below it is held high, so that cell closes the period.

The ratio is taken in at the instant each period closes, so a new value never cuts a period short or stretches it. A value below the legal floor is raised to the floor. The block sits behind a prescaler phase selector in a synthesizer loop and is clocked by the selected phase.

Top module: `casc_div`

## Requirements
- R1: While `rst_ni` is low, `div_o` is 0. The ratio present at the first clock edge after reset release is captured, and the first `div_o` pulse appears exactly that many clock edges later.
- R2: For a ratio from 64 to 127 (unsigned binary on `ratio_i`, top bit set), consecutive `div_o` pulses are exactly `ratio` clock cycles apart.
- R3: For a ratio from 32 to 63 (top bit clear, next bit set), consecutive `div_o` pulses are exactly `ratio` clock cycles apart. This is the bypass mode.
- R4: A ratio below 32 is treated as 32.
- R5: `ratio_i` is sampled only at the clock edge where `div_o` rises, and it sets the length of the period that starts there. A change at any other time has no effect on the period in progress.
- R6: Each `div_o` pulse is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 7 | Division ratio, unsigned, legal range 32 to 127 |
| div_o | output | 1 | One-cycle pulse per divided period |

## Verification
Every ratio from 32 to 127 is applied in turn. This separates the full six-cell chain from the bypassed five-cell chain, and it exercises every program bit pattern, including the 63/64 crossing where the mode changes. Ratios of 0, 7 and 31 show whether clamping acts or whether the raw value reaches the cells. A phase that moves the ratio in the middle of a period, across both modes, tells sampling at the period end apart from sampling at any other time. A behavioural counting model in the bench predicts `div_o` for every cycle.

// File: rtl/casc_div_pkg.sv
package casc_div_pkg;
  function automatic int floor_ratio(int cells);
    return 1 << (cells - 1);
  endfunction

  function automatic int ceil_ratio(int cells);
    return (1 << (cells + 1)) - 1;
  endfunction
endpackage

// File: rtl/casc_div_cell.sv
module casc_div_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic prog_i,
  input  logic mod_i,
  output logic out_o,
  output logic mod_o
);
  logic [1:0] cnt_q;
  logic [1:0] last;
  logic       at_last;

  // swallow one extra input event when programmed and asked to
  assign last    = (prog_i && mod_i) ? 2'd2 : 2'd1;
  assign at_last = (cnt_q >= last);
  assign out_o   = en_i && at_last;
  assign mod_o   = mod_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= 2'd0;
    else if (en_i) cnt_q <= at_last ? 2'd0 : cnt_q + 2'd1;
  end
endmodule

// File: rtl/casc_div_ratio.sv
module casc_div_ratio #(
  parameter int CELLS = 6,
  localparam int RW = CELLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RW-1:0] ratio_i,
  output logic [RW-1:0] ratio_o
);
  import casc_div_pkg::*;
  localparam logic [RW-1:0] FLOOR = RW'(floor_ratio(CELLS));

  logic [RW-1:0] ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_q <= FLOOR;
    else if (load_i) ratio_q <= (ratio_i < FLOOR) ? FLOOR : ratio_i;
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/casc_div_chain.sv
module casc_div_chain #(
  parameter int CELLS = 6,
  localparam int RW = CELLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [RW-1:0] ratio_i,
  output logic          wrap_o
);
  logic             bypass;
  logic [CELLS-1:0] en;
  logic [CELLS-1:0] fire;
  logic [CELLS-1:0] mod_in;
  logic [CELLS-1:0] mod_out;

  // top ratio bit clear: drop the top cell, the next one closes the period
  assign bypass = !ratio_i[CELLS];

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    if (k == 0) begin : g_en_first
      assign en[k] = run_i;
    end else if (k == CELLS - 1) begin : g_en_top
      assign en[k] = fire[k-1] && !bypass;
    end else begin : g_en_mid
      assign en[k] = fire[k-1];
    end

    if (k == CELLS - 1) begin : g_mod_top
      assign mod_in[k] = 1'b1;
    end else if (k == CELLS - 2) begin : g_mod_sub
      assign mod_in[k] = bypass || mod_out[k+1];
    end else begin : g_mod_mid
      assign mod_in[k] = mod_out[k+1];
    end

    casc_div_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[k]),
      .prog_i (ratio_i[k]),
      .mod_i  (mod_in[k]),
      .out_o  (fire[k]),
      .mod_o  (mod_out[k])
    );
  end

  // period end: selected top cell fires while the modulus chain is aligned
  assign wrap_o = mod_out[0] && (bypass ? fire[CELLS-2] : fire[CELLS-1]);
endmodule

// File: rtl/casc_div.sv
module casc_div #(
  parameter int CELLS = 6,
  localparam int RW = CELLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          div_o
);
  logic          start_q;
  logic          wrap;
  logic          load;
  logic [RW-1:0] ratio_cur;

  // first edge after reset only captures the ratio
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      div_o   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      div_o   <= wrap;
    end
  end

  assign load = start_q || wrap;

  casc_div_ratio #(.CELLS(CELLS)) u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .ratio_i (ratio_i),
    .ratio_o (ratio_cur)
  );

  casc_div_chain #(.CELLS(CELLS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (!start_q),
    .ratio_i (ratio_cur),
    .wrap_o  (wrap)
  );
endmodule

// File: rtl/casc_div_chk.sv
module casc_div_chk #(
  parameter int CELLS = 6,
  localparam int RW = CELLS + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          div_o,
  input logic          load,
  input logic [RW-1:0] ratio_cur
);
  import casc_div_pkg::*;
  localparam int FLOOR = floor_ratio(CELLS);
  localparam int CEIL  = ceil_ratio(CELLS);
  localparam int GW    = $clog2(CEIL + 2);

  logic          seen_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (div_o) begin
      seen_q <= 1'b1;
      gap_q  <= GW'(1);
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  assert_period_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && seen_q) |-> (gap_q >= GW'(FLOOR)));

  assert_period_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (gap_q <= GW'(CEIL)));

  assert_ratio_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(ratio_cur));

  assert_pulse_after_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> $past(load));

  assert_ratio_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_cur >= RW'(FLOOR));
endmodule

bind casc_div casc_div_chk #(.CELLS(CELLS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_o     (div_o),
  .load      (load),
  .ratio_cur (ratio_cur)
);

// File: tb/casc_div_bench.sv
module casc_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS      = 6;
  localparam int RW         = CELLS + 1;
  localparam int LIMIT      = 200000;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio = RW'(100);
  logic          div_o;

  casc_div #(.CELLS(CELLS)) u_casc_div (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ratio_i (ratio),
    .div_o   (div_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    started = 0;
  bit    exp_o = 0;
  bit    prev_exp = 0;
  int    left = 0;
  string tag_cur = "R1";
  string tag_chk = "R1";
  string phase_tag = "";

  function automatic int eff(int raw);
    return (raw < 32) ? 32 : raw;
  endfunction

  function automatic string cat(int raw);
    if (raw < 32) return "R4";
    if (raw < 64) return "R3";
    return "R2";
  endfunction

  task automatic check(bit act, bit expv, string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: div_o=%0b expected %0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference: count clock edges down from the captured ratio
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  = 0;
      exp_o    = 0;
      prev_exp = 0;
      tag_cur  = "R1";
      tag_chk  = "R1";
    end else begin
      prev_exp = exp_o;
      tag_chk  = tag_cur;
      if (!started) begin
        started = 1;
        left    = eff(int'(ratio));
        exp_o   = 0;
      end else begin
        left--;
        if (left == 0) begin
          exp_o   = 1;
          left    = eff(int'(ratio));
          tag_cur = (phase_tag != "") ? phase_tag : cat(int'(ratio));
        end else begin
          exp_o = 0;
        end
      end
      if (!exp_o && prev_exp) tag_chk = "R6";
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) check(div_o, 1'b0, "R1");
      else        check(div_o, exp_o, tag_chk);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog R2: run hung, actual %0d cycles, expected at most %0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic wait_pulses(int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (div_o) k++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_pulses(2);

    // R2 and R3: full sweep across both chain modes
    for (int r = 32; r <= 127; r++) begin
      ratio = RW'(r);
      wait_pulses(2);
    end

    // R4: values below the floor
    ratio = RW'(0);
    wait_pulses(2);
    ratio = RW'(7);
    wait_pulses(2);
    ratio = RW'(31);
    wait_pulses(2);

    // R5: ratio moved inside a period
    phase_tag = "R5";
    ratio = RW'(127);
    wait_pulses(2);
    repeat (10) @(negedge clk);
    ratio = RW'(40);
    repeat (30) @(negedge clk);
    ratio = RW'(90);
    wait_pulses(1);
    repeat (5) @(negedge clk);
    ratio = RW'(33);
    wait_pulses(3);

    finish_run();
  end
endmodule